// File: doc/BRIEF.md
# Serial-In Latched Output Driver

This block converts a serial bit stream into a 32-bit parallel output word, as used to drive a row of display segments. Bits enter a shift register on each rising clock edge and move one stage per edge toward a serial cascade output, so several blocks can be chained to form a wider word. A bank of latches sits between the register and the outputs. The latches take the register contents on every edge where the strobe is high, and they hold their value while the strobe is low. An active-high blank input turns every output off. It does not alter the latched data, so the previous pattern comes back as soon as blank is released.

The latch stage is modelled in synchronous logic. On a clock edge where strobe is sampled high, the latches load the value the shift register takes at that same edge. The latches therefore track the register edge for edge while strobe stays high. If strobe is tied high, the latches are bypassed in effect, and blank must be held high during serial entry so that the outputs do not ripple. A synchronous reset clears both the register and the latches.

Top module: `serial_latch_driver`

## Requirements
- R1: A rising clock edge with `rst` high clears every shift stage and every latch to 0, so `dout` and `sdo` read 0 afterwards.
- R2: On each rising edge with `rst` low, `sdi` is captured into stage 0 and every stage k moves to stage k+1. `sdi` is sampled only at that edge.
- R3: `sdo` is the highest stage (WIDTH-1). A bit applied to `sdi` appears on `sdo` after exactly WIDTH rising edges.
- R4: On a rising edge where `strobe` is high, every latch loads the value its shift stage takes at that same edge.
- R5: On a rising edge where `strobe` is low, every latch keeps its value, whatever shifting takes place.
- R6: While `blank` is high, all `dout` bits are 0, without waiting for a clock edge.
- R7: `blank` never changes latch contents. When `blank` returns low, `dout` shows the latched word again, including any load made while blanked.
- R8: While `blank` is low, `dout[k]` equals latch k.
- R9: Bit order: after WIDTH edges, the first bit shifted in sits in stage WIDTH-1 and appears on `dout[WIDTH-1]`; the last bit shifted in appears on `dout[0]`.
- R10: With `strobe` held high and `blank` low, `dout` matches the shift register after every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and latch clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data in |
| strobe | input | 1 | Latch load enable, active high |
| blank | input | 1 | Output blanking, active high |
| dout | output | WIDTH (32) | Parallel output word |
| sdo | output | 1 | Serial cascade output (last stage) |

## Verification
Two cases need the most care. The first is a latch load made while the outputs are blanked. It can only be seen once blank drops, so the bench raises blank, strobes in a fresh word, and only then releases blank. The second is the cascade delay. It shows on `sdo` only WIDTH edges later, so after a known word has been strobed in, the bench shifts a second word and predicts each bit of the first word as it leaves `sdo`. Sweeps over many computed words with strobe held high cover transparent operation.

// File: rtl/sld_pkg.sv
package sld_pkg;

    localparam int SLD_WIDTH = 32;

    typedef logic [SLD_WIDTH-1:0] sld_word_t;

    typedef enum logic [1:0] {
        SLD_RESET = 2'b00,
        SLD_SHIFT = 2'b01
    } sld_op_e;

endpackage

// File: rtl/sld_shift_stage.sv
module sld_shift_stage #(
    parameter int WIDTH = sld_pkg::SLD_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdi,
    output logic [WIDTH-1:0] next_o,
    output logic [WIDTH-1:0] stages_o,
    output logic             sdo
);
    import sld_pkg::*;

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shift_state_t;

    shift_state_t st_d, st_q;
    sld_op_e      op;

    always_comb begin
        op = rst ? SLD_RESET : SLD_SHIFT;
        st_d = st_q;
        case (op)
            SLD_RESET: st_d.bits = '0;
            default:   st_d.bits = {st_q.bits[TOP-1:0], sdi};
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign next_o   = st_d.bits;
    assign stages_o = st_q.bits;
    assign sdo      = st_q.bits[TOP];

endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
    parameter int WIDTH = sld_pkg::SLD_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] next_i,
    output logic [WIDTH-1:0] latch_o
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } latch_state_t;

    latch_state_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (load) begin
            lat_d.bits = next_i;
        end
        if (rst) begin
            lat_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        lat_q <= lat_d;
    end

    assign latch_o = lat_q.bits;

endmodule

// File: rtl/sld_blank_gate.sv
module sld_blank_gate #(
    parameter int WIDTH = sld_pkg::SLD_WIDTH
) (
    input  logic             blank,
    input  logic [WIDTH-1:0] latch_i,
    output logic [WIDTH-1:0] dout
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign dout[k] = latch_i[k] & ~blank;
    end

endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
    parameter int WIDTH = sld_pkg::SLD_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdi,
    input  logic             strobe,
    input  logic             blank,
    output logic [WIDTH-1:0] dout,
    output logic             sdo
);
    logic [WIDTH-1:0] next_w;
    logic [WIDTH-1:0] shift_w;
    logic [WIDTH-1:0] latch_w;

    sld_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sdi      (sdi),
        .next_o   (next_w),
        .stages_o (shift_w),
        .sdo      (sdo)
    );

    sld_latch_bank #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (strobe),
        .next_i  (next_w),
        .latch_o (latch_w)
    );

    sld_blank_gate #(.WIDTH(WIDTH)) u_gate (
        .blank   (blank),
        .latch_i (latch_w),
        .dout    (dout)
    );

endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             sdi,
    input logic             strobe,
    input logic             blank,
    input logic [WIDTH-1:0] dout,
    input logic             sdo,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] latch_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sdo == 1'b0 && dout == '0 && latch_q == '0));

    a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(sdi)});

    a_r3_cascade_tail: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sdo == $past(shift_q[WIDTH-2]));

    a_r4_strobe_load: assert property (@(posedge clk) disable iff (rst)
        strobe |=> latch_q == shift_q);

    a_r5_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(latch_q));

    a_r6_blank_off: assert property (@(posedge clk) disable iff (rst)
        blank |-> dout == '0);

    a_r8_unblank_show: assert property (@(posedge clk) disable iff (rst)
        !blank |-> dout == latch_q);

endmodule

bind serial_latch_driver sld_checker #(.WIDTH(WIDTH)) u_sld_checker (
    .clk     (clk),
    .rst     (rst),
    .sdi     (sdi),
    .strobe  (strobe),
    .blank   (blank),
    .dout    (dout),
    .sdo     (sdo),
    .shift_q (shift_w),
    .latch_q (latch_w)
);

// File: tb/serial_latch_driver_bench.sv
`timescale 1ns/1ps
module serial_latch_driver_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst, sdi, strobe, blank;
    logic [W-1:0] dout;
    logic         sdo;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [W-1:0] m_sh, m_la;

    always #2.5 clk = ~clk;

    serial_latch_driver #(.WIDTH(W)) u_serial_latch_driver (
        .clk(clk), .rst(rst), .sdi(sdi), .strobe(strobe),
        .blank(blank), .dout(dout), .sdo(sdo)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [W-1:0] nx;
        @(posedge clk);
        if (rst) begin
            m_sh = '0;
            m_la = '0;
        end else begin
            nx = {m_sh[W-2:0], sdi};
            if (strobe) m_la = nx;
            m_sh = nx;
        end
        #1;
    endtask

    function automatic logic [W-1:0] exp_out();
        return blank ? '0 : m_la;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] p, q, w;
        m_sh = 'x; m_la = 'x;
        rst = 1; sdi = 0; strobe = 0; blank = 0;
        step(); step();
        chk("R1 reset dout", dout, '0);
        chk("R1 reset sdo", {{(W-1){1'b0}}, sdo}, '0);
        rst = 0;

        // R2 R5 R9: shift a word with strobe low, strobe only on its last bit
        p = 32'hA5C3_0F96;
        for (int k = 0; k < W; k++) begin
            sdi = p[W-1-k];
            strobe = (k == W-1);
            step();
            if (k < W-1) chk("R5 hold while shifting", dout, '0);
            chk("R2 sdo tracks register", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, m_sh[W-1]});
        end
        chk("R9 bit order first-in at top", dout, p);
        chk("R4 strobe loads", dout, m_la);
        strobe = 0;

        // R3: second word pushes the first out of sdo, first-in first
        q = 32'h1234_5678;
        for (int k = 0; k < W; k++) begin
            chk("R3 cascade out", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, p[W-1-k]});
            sdi = q[W-1-k];
            step();
            chk("R5 hold with strobe low", dout, p);
        end
        chk("R3 sdo after full word", {{(W-1){1'b0}}, sdo}, {{(W-1){1'b0}}, q[W-1]});

        // R6 R7: blank, load while blanked, unblank
        blank = 1; #1;
        chk("R6 blank immediate", dout, '0);
        sdi = 1; strobe = 1;
        step();
        chk("R6 blank during load", dout, '0);
        strobe = 0; sdi = 0;
        step(); step();
        chk("R6 blank held", dout, '0);
        blank = 0; #1;
        chk("R7 latched load reappears", dout, {q[W-2:0], 1'b1});
        chk("R8 unblanked shows latch", dout, m_la);
        blank = 1; #1;
        blank = 0; #1;
        chk("R7 blank pulse no change", dout, {q[W-2:0], 1'b1});

        // R10 R8: sweep with strobe held high (transparent)
        strobe = 1;
        for (int n = 0; n < 24; n++) begin
            w = (32'h9E37_79B9 * (n + 1)) ^ (32'h1 << n);
            for (int k = 0; k < W; k++) begin
                sdi = w[W-1-k];
                step();
                chk("R10 transparent follow", dout, m_sh);
            end
            chk("R10 sweep word", dout, w);
        end

        // R6 across a transparent burst
        blank = 1;
        for (int k = 0; k < 8; k++) begin
            sdi = k[0];
            step();
            chk("R6 blank during entry", dout, exp_out());
        end
        blank = 0; #1;
        chk("R8 after burst", dout, m_sh);
        strobe = 0;

        // R1 mid-run reset
        rst = 1;
        step();
        chk("R1 mid-run reset dout", dout, '0);
        chk("R1 mid-run reset sdo", {{(W-1){1'b0}}, sdo}, '0);
        rst = 0;
        strobe = 1; sdi = 0;
        step();
        chk("R1 register cleared", dout, '0);

        finish_run();
    end

endmodule